// File: doc/BRIEF.md
# Enable-Pin Sleep Sequencer with Gate Shutoff Arbitration

This block decides when a gate-driver chip is awake and what its gate outputs are allowed to do. A single enable pin drives it in both directions. While the pin stays high, the block runs a timed power-up and then reports that active operation is ready. When the pin drops, the block does not act at once. It first waits out a deglitch interval. It then clamps every gate with the strong (active) pulldown. After a fixed hold period it turns the internal supplies off and falls back to the weak semi-active plus passive pulldown. Entering sleep holds the logic in reset and issues a one-cycle strobe that clears the configuration registers.

All timing is counted in ticks of an external one-microsecond strobe. In active operation a combinational arbiter chooses the gate mode from the chip reset pin, the driver-off pin and the non-masked error flag, in that priority. Only when none of them asks for shutoff do the gate commands pass through to the gate outputs. The enable input must already be synchronous to the clock.

Top module: `en_sleep_seq`

## Requirements
- R1: While and after synchronous reset, with the enable pin low, the block is asleep: `gate_mode` is 2'b10 (semi-active plus passive pulldown), `supply_en` = 0, `logic_rst` = 1, `active_ready` = 0, `reg_clr` = 0 and `gate_out` = 0.
- R2: Enable high while asleep raises `supply_en` one clock later. `active_ready` rises on the POWERUP_US-th tick after that and not before. During the power-up interval the mode stays 2'b10 and `logic_rst` stays 1.
- R3: In active operation the arbiter applies these rules in order. Reset pin low gives `gate_mode` 2'b01 (active pulldown) with `logic_rst` = 1. Otherwise, driver-off high gives 2'b01 with `logic_rst` = 0. Otherwise, the error flag high gives 2'b01 with `logic_rst` = 0. Otherwise the mode is 2'b00 (follow commands) with `logic_rst` = 0.
- R4: An enable low pulse lasting fewer than DEGLITCH_US ticks is ignored. `active_ready` stays 1, the mode keeps following R3, and no `reg_clr` is issued.
- R5: Enable held low for DEGLITCH_US ticks forces `gate_mode` 2'b01 with `supply_en` still 1 and `active_ready` 0. In this phase `logic_rst` equals the inverse of the reset pin.
- R6: Exactly PULLDOWN_US ticks (default 28) after the active pulldown starts, the block falls asleep. `supply_en` goes to 0, the mode goes to 2'b10, `logic_rst` goes to 1, and `reg_clr` is high for exactly one clock.
- R7: While asleep, the reset pin, driver-off pin, error flag and gate commands have no effect on any output.
- R8: Enable returning high during the active pulldown phase puts the block back in active operation one clock later. There is no power-up wait and no `reg_clr`.
- R9: Enable dropping low during power-up returns the block to sleep one clock later, with `supply_en` = 0.
- R10: `gate_out` equals `gate_cmd` only when `gate_mode` is 2'b00. In every other mode it is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_us | input | 1 | One-cycle strobe once per microsecond |
| en_pin | input | 1 | Enable pin, already synchronous to clk |
| rstn_pin | input | 1 | Chip reset pin, active low |
| drv_off | input | 1 | Driver-off request, active high |
| err_any | input | 1 | Any non-masked error present |
| gate_cmd | input | NGATE | Normal gate commands |
| gate_mode | output | 2 | 00 follow, 01 active pulldown, 10 semi-active plus passive pulldown |
| gate_out | output | NGATE | Gate commands after arbitration |
| supply_en | output | 1 | Internal supplies enabled |
| logic_rst | output | 1 | Internal logic held in reset |
| reg_clr | output | 1 | One-cycle configuration register clear strobe |
| active_ready | output | 1 | Active operation reached |

## Verification
The hardest situations to reach are the edges of the timing windows. One is an enable dip that lasts exactly one tick less than the deglitch interval. Another is a return of enable during the active pulldown phase, landing a few ticks before the supplies would drop. The stimulus reaches both by counting tick strobes from the bench. It drives glitches of random length below the limit, then the full-length drop, then an abort part-way through the pulldown. The arbitration priority is checked with random combinations of reset, driver-off, error and gate commands while the block is active.

// File: rtl/ess_pkg.sv
package ess_pkg;

    // Gate mode code seen at the port
    typedef enum logic [1:0] {
        GM_FOLLOW    = 2'b00,
        GM_ACTIVE_PD = 2'b01,
        GM_SEMI_PD   = 2'b10
    } gate_mode_e;

    typedef enum logic [2:0] {
        ST_SLEEP,
        ST_POWERUP,
        ST_ACTIVE,
        ST_DEGLITCH,
        ST_PULLDOWN
    } seq_state_e;

    // Shutoff request bundle from the pins
    typedef struct packed {
        logic rstn;
        logic drv_off;
        logic err;
    } shutoff_req_t;

    // Arbitration result
    typedef struct packed {
        gate_mode_e mode;
        logic       logic_rst;
    } shutoff_res_t;

    function automatic int unsigned max3(input int unsigned a, input int unsigned b,
                                         input int unsigned c);
        int unsigned m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction

    function automatic logic is_timed(input seq_state_e st);
        return (st == ST_POWERUP) || (st == ST_DEGLITCH) || (st == ST_PULLDOWN);
    endfunction

    function automatic logic is_awake(input seq_state_e st);
        return (st == ST_ACTIVE) || (st == ST_DEGLITCH);
    endfunction

    // Priority: reset pin, then driver-off, then error, then normal inputs
    function automatic shutoff_res_t resolve(input seq_state_e st, input shutoff_req_t rq);
        shutoff_res_t r;
        case (st)
            ST_SLEEP, ST_POWERUP: begin
                r.mode      = GM_SEMI_PD;
                r.logic_rst = 1'b1;
            end
            ST_PULLDOWN: begin
                r.mode      = GM_ACTIVE_PD;
                r.logic_rst = ~rq.rstn;
            end
            default: begin
                if (!rq.rstn) begin
                    r.mode      = GM_ACTIVE_PD;
                    r.logic_rst = 1'b1;
                end else if (rq.drv_off || rq.err) begin
                    r.mode      = GM_ACTIVE_PD;
                    r.logic_rst = 1'b0;
                end else begin
                    r.mode      = GM_FOLLOW;
                    r.logic_rst = 1'b0;
                end
            end
        endcase
        return r;
    endfunction

endpackage

// File: rtl/ess_timer.sv
module ess_timer #(
    parameter int unsigned CW = 12
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          run,
    input  logic          tick,
    input  logic [CW-1:0] limit,
    output logic          done
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q <= '0;
        end else if (run && tick) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // The tick that completes the interval
    assign done = run && tick && (cnt_q == (limit - 1'b1));

endmodule

// File: rtl/ess_fsm.sv
module ess_fsm
    import ess_pkg::*;
#(
    parameter int unsigned CW          = 12,
    parameter int unsigned DEGLITCH_US = 6,
    parameter int unsigned PULLDOWN_US = 28,
    parameter int unsigned POWERUP_US  = 3000
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en_pin,
    input  logic          done,
    output seq_state_e    state,
    output logic [CW-1:0] limit,
    output logic          run,
    output logic          clr,
    output logic          reg_clr
);
    seq_state_e state_q, state_d;
    logic       reg_clr_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SLEEP:    if (en_pin) state_d = ST_POWERUP;
            ST_POWERUP:  if (!en_pin) state_d = ST_SLEEP;
                         else if (done) state_d = ST_ACTIVE;
            ST_ACTIVE:   if (!en_pin) state_d = ST_DEGLITCH;
            ST_DEGLITCH: if (en_pin) state_d = ST_ACTIVE;
                         else if (done) state_d = ST_PULLDOWN;
            ST_PULLDOWN: if (en_pin) state_d = ST_ACTIVE;
                         else if (done) state_d = ST_SLEEP;
            default:     state_d = ST_SLEEP;
        endcase
    end

    always_comb begin
        unique case (state_q)
            ST_POWERUP:  limit = CW'(POWERUP_US);
            ST_DEGLITCH: limit = CW'(DEGLITCH_US);
            ST_PULLDOWN: limit = CW'(PULLDOWN_US);
            default:     limit = CW'(1);
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q   <= ST_SLEEP;
            reg_clr_q <= 1'b0;
        end else begin
            state_q   <= state_d;
            reg_clr_q <= (state_q == ST_PULLDOWN) && (state_d == ST_SLEEP);
        end
    end

    assign state   = state_q;
    assign run     = is_timed(state_q);
    assign clr     = (state_d != state_q);
    assign reg_clr = reg_clr_q;

endmodule

// File: rtl/ess_arbiter.sv
module ess_arbiter
    import ess_pkg::*;
#(
    parameter int unsigned NGATE = 6
) (
    input  seq_state_e       state,
    input  logic             rstn_pin,
    input  logic             drv_off,
    input  logic             err_any,
    input  logic [NGATE-1:0] gate_cmd,
    output gate_mode_e       mode,
    output logic             logic_rst,
    output logic [NGATE-1:0] gate_out
);
    shutoff_req_t req;
    shutoff_res_t res;
    logic         pass;

    always_comb begin
        req.rstn    = rstn_pin;
        req.drv_off = drv_off;
        req.err     = err_any;
        res         = resolve(state, req);
    end

    assign mode      = res.mode;
    assign logic_rst = res.logic_rst;
    assign pass      = (res.mode == GM_FOLLOW);

    for (genvar g = 0; g < NGATE; g++) begin : g_gate
        assign gate_out[g] = pass & gate_cmd[g];
    end

endmodule

// File: rtl/en_sleep_seq.sv
module en_sleep_seq
    import ess_pkg::*;
#(
    parameter int unsigned NGATE       = 6,
    parameter int unsigned DEGLITCH_US = 6,
    parameter int unsigned PULLDOWN_US = 28,
    parameter int unsigned POWERUP_US  = 3000
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_us,
    input  logic             en_pin,
    input  logic             rstn_pin,
    input  logic             drv_off,
    input  logic             err_any,
    input  logic [NGATE-1:0] gate_cmd,
    output logic [1:0]       gate_mode,
    output logic [NGATE-1:0] gate_out,
    output logic             supply_en,
    output logic             logic_rst,
    output logic             reg_clr,
    output logic             active_ready
);
    localparam int unsigned MAXLIM = max3(DEGLITCH_US, PULLDOWN_US, POWERUP_US);
    localparam int unsigned CW     = $clog2(MAXLIM + 1);

    seq_state_e    state;
    logic [CW-1:0] limit;
    logic          run, clr, done;
    gate_mode_e    mode;

    ess_timer #(.CW(CW)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clr   (clr),
        .run   (run),
        .tick  (tick_us),
        .limit (limit),
        .done  (done)
    );

    ess_fsm #(
        .CW          (CW),
        .DEGLITCH_US (DEGLITCH_US),
        .PULLDOWN_US (PULLDOWN_US),
        .POWERUP_US  (POWERUP_US)
    ) u_fsm (
        .clk     (clk),
        .rst     (rst),
        .en_pin  (en_pin),
        .done    (done),
        .state   (state),
        .limit   (limit),
        .run     (run),
        .clr     (clr),
        .reg_clr (reg_clr)
    );

    ess_arbiter #(.NGATE(NGATE)) u_arb (
        .state     (state),
        .rstn_pin  (rstn_pin),
        .drv_off   (drv_off),
        .err_any   (err_any),
        .gate_cmd  (gate_cmd),
        .mode      (mode),
        .logic_rst (logic_rst),
        .gate_out  (gate_out)
    );

    assign gate_mode    = mode;
    assign supply_en    = (state != ST_SLEEP);
    assign active_ready = is_awake(state);

endmodule

// File: rtl/ess_checker.sv
module ess_checker #(
    parameter int unsigned NGATE = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             en_pin,
    input logic             rstn_pin,
    input logic             drv_off,
    input logic [NGATE-1:0] gate_cmd,
    input logic [1:0]       gate_mode,
    input logic [NGATE-1:0] gate_out,
    input logic             supply_en,
    input logic             logic_rst,
    input logic             reg_clr,
    input logic             active_ready
);
    assert_ready_has_supply_R2: assert property (@(posedge clk) disable iff (rst)
        active_ready |-> supply_en);

    assert_supply_rise_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(supply_en) |-> $past(en_pin));

    assert_drvoff_pulldown_R3: assert property (@(posedge clk) disable iff (rst)
        (active_ready && rstn_pin && drv_off) |-> (gate_mode == 2'b01 && !logic_rst));

    assert_stay_ready_R4: assert property (@(posedge clk) disable iff (rst)
        (active_ready && en_pin) |=> active_ready);

    assert_clr_single_R6: assert property (@(posedge clk) disable iff (rst)
        reg_clr |=> !reg_clr);

    assert_clr_asleep_R6: assert property (@(posedge clk) disable iff (rst)
        reg_clr |-> (!supply_en && $past(supply_en)));

    assert_sleep_outputs_R7: assert property (@(posedge clk) disable iff (rst)
        !supply_en |-> (gate_mode == 2'b10 && logic_rst && gate_out == '0));

    assert_gate_block_R10: assert property (@(posedge clk) disable iff (rst)
        (gate_mode != 2'b00) |-> (gate_out == '0));

    assert_gate_pass_R10: assert property (@(posedge clk) disable iff (rst)
        (gate_mode == 2'b00) |-> (gate_out == gate_cmd));

endmodule

bind en_sleep_seq ess_checker #(.NGATE(NGATE)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .en_pin       (en_pin),
    .rstn_pin     (rstn_pin),
    .drv_off      (drv_off),
    .gate_cmd     (gate_cmd),
    .gate_mode    (gate_mode),
    .gate_out     (gate_out),
    .supply_en    (supply_en),
    .logic_rst    (logic_rst),
    .reg_clr      (reg_clr),
    .active_ready (active_ready)
);

// File: tb/tb_en_sleep_seq.sv
module tb_en_sleep_seq;
    localparam int NG  = 6;
    localparam int DEG = 6;
    localparam int PD  = 28;
    localparam int PU  = 20;

    logic          clk = 1'b0;
    logic          rst, tick_us, en_pin, rstn_pin, drv_off, err_any;
    logic [NG-1:0] gate_cmd, gate_out;
    logic [1:0]    gate_mode;
    logic          supply_en, logic_rst, reg_clr, active_ready;
    int            checks = 0;
    int            errors = 0;

    always #2 clk = ~clk;

    en_sleep_seq #(.NGATE(NG), .DEGLITCH_US(DEG), .PULLDOWN_US(PD), .POWERUP_US(PU)) dut (
        .clk(clk), .rst(rst), .tick_us(tick_us), .en_pin(en_pin), .rstn_pin(rstn_pin),
        .drv_off(drv_off), .err_any(err_any), .gate_cmd(gate_cmd), .gate_mode(gate_mode),
        .gate_out(gate_out), .supply_en(supply_en), .logic_rst(logic_rst),
        .reg_clr(reg_clr), .active_ready(active_ready)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] exp_mode(input logic rn, input logic dof, input logic er);
        if (!rn || dof || er) return 2'b01;
        return 2'b00;
    endfunction

    function automatic logic exp_lrst(input logic rn);
        return !rn;
    endfunction

    task automatic tick_pulse();
        @(negedge clk); tick_us = 1'b1;
        @(negedge clk); tick_us = 1'b0;
    endtask

    task automatic do_ticks(input int n);
        for (int k = 0; k < n; k++) tick_pulse();
    endtask

    task automatic check_asleep(input string req);
        chk(req, "gate_mode", 32'(gate_mode), 32'h2);
        chk(req, "supply_en", 32'(supply_en), 32'h0);
        chk(req, "logic_rst", 32'(logic_rst), 32'h1);
        chk(req, "ready", 32'(active_ready), 32'h0);
        chk(req, "gate_out", 32'(gate_out), 32'h0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        rst = 1'b1; tick_us = 1'b0; en_pin = 1'b0; rstn_pin = 1'b1;
        drv_off = 1'b0; err_any = 1'b0; gate_cmd = '0;
        repeat (3) @(negedge clk);
        check_asleep("R1");
        rst = 1'b0;
        @(negedge clk);
        check_asleep("R1");
        chk("R1", "reg_clr", 32'(reg_clr), 32'h0);

        // R9: abort power-up
        en_pin = 1'b1;
        @(negedge clk);
        chk("R2", "supply_en early", 32'(supply_en), 32'h1);
        do_ticks(3);
        en_pin = 1'b0;
        @(negedge clk);
        chk("R9", "supply_en", 32'(supply_en), 32'h0);
        chk("R9", "ready", 32'(active_ready), 32'h0);

        // R7: pins ignored in sleep
        rstn_pin = 1'b0; drv_off = 1'b1; err_any = 1'b1; gate_cmd = '1;
        repeat (4) @(negedge clk);
        check_asleep("R7");
        rstn_pin = 1'b1; drv_off = 1'b0; err_any = 1'b0; gate_cmd = 6'h2d;

        // R2: full power-up
        en_pin = 1'b1;
        @(negedge clk);
        do_ticks(PU - 1);
        chk("R2", "ready before end", 32'(active_ready), 32'h0);
        chk("R2", "mode in powerup", 32'(gate_mode), 32'h2);
        chk("R2", "lrst in powerup", 32'(logic_rst), 32'h1);
        do_ticks(1);
        chk("R2", "ready at end", 32'(active_ready), 32'h1);
        chk("R10", "gate_out pass", 32'(gate_out), 32'h2d);

        // R3/R10: random arbitration
        for (int i = 0; i < 150; i++) begin
            @(negedge clk);
            rstn_pin = ($urandom_range(0, 3) != 0);
            drv_off  = ($urandom_range(0, 2) == 0);
            err_any  = ($urandom_range(0, 2) == 0);
            gate_cmd = NG'($urandom);
            #1;
            chk("R3", "mode", 32'(gate_mode), 32'(exp_mode(rstn_pin, drv_off, err_any)));
            chk("R3", "logic_rst", 32'(logic_rst), 32'(exp_lrst(rstn_pin)));
            chk("R10", "gate_out", 32'(gate_out),
                32'((exp_mode(rstn_pin, drv_off, err_any) == 2'b00) ? gate_cmd : '0));
        end
        @(negedge clk);
        rstn_pin = 1'b0; drv_off = 1'b1; err_any = 1'b1; #1;
        chk("R3", "reset wins lrst", 32'(logic_rst), 32'h1);
        rstn_pin = 1'b1; #1;
        chk("R3", "drvoff lrst", 32'(logic_rst), 32'h0);
        chk("R3", "drvoff mode", 32'(gate_mode), 32'h1);
        drv_off = 1'b0; err_any = 1'b0; gate_cmd = 6'h15;

        // R4: glitches shorter than deglitch
        for (int g = 0; g < 5; g++) begin
            int len;
            len = (g == 0) ? DEG - 1 : int'($urandom_range(1, DEG - 1));
            @(negedge clk);
            en_pin = 1'b0;
            do_ticks(len);
            chk("R4", "ready during glitch", 32'(active_ready), 32'h1);
            chk("R4", "mode during glitch", 32'(gate_mode), 32'h0);
            en_pin = 1'b1;
            @(negedge clk);
            chk("R4", "ready after glitch", 32'(active_ready), 32'h1);
            chk("R4", "reg_clr", 32'(reg_clr), 32'h0);
        end

        // R5: full deglitch then active pulldown
        en_pin = 1'b0;
        do_ticks(DEG);
        chk("R5", "mode", 32'(gate_mode), 32'h1);
        chk("R5", "ready", 32'(active_ready), 32'h0);
        chk("R5", "supply_en", 32'(supply_en), 32'h1);
        chk("R10", "gate_out in pd", 32'(gate_out), 32'h0);
        rstn_pin = 1'b0; #1;
        chk("R5", "lrst rstn low", 32'(logic_rst), 32'h1);
        rstn_pin = 1'b1; #1;
        chk("R5", "lrst rstn high", 32'(logic_rst), 32'h0);

        // R8: abort sleep entry
        do_ticks(10);
        en_pin = 1'b1;
        @(negedge clk);
        chk("R8", "ready", 32'(active_ready), 32'h1);
        chk("R8", "mode", 32'(gate_mode), 32'h0);
        chk("R8", "supply_en", 32'(supply_en), 32'h1);
        chk("R8", "reg_clr", 32'(reg_clr), 32'h0);
        chk("R8", "gate_out", 32'(gate_out), 32'h15);

        // R6: complete sleep entry
        en_pin = 1'b0;
        do_ticks(DEG);
        do_ticks(PD - 1);
        chk("R6", "mode before end", 32'(gate_mode), 32'h1);
        chk("R6", "supply before end", 32'(supply_en), 32'h1);
        chk("R6", "reg_clr before end", 32'(reg_clr), 32'h0);
        tick_pulse();
        chk("R6", "reg_clr strobe", 32'(reg_clr), 32'h1);
        check_asleep("R6");
        @(negedge clk);
        chk("R6", "reg_clr single", 32'(reg_clr), 32'h0);

        // R7: reset pin low after sleep reached
        rstn_pin = 1'b0; drv_off = 1'b1; gate_cmd = '1;
        repeat (5) @(negedge clk);
        check_asleep("R7");
        chk("R7", "reg_clr", 32'(reg_clr), 32'h0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule